// File: doc/BRIEF.md
# Write-back MSI snooping cache controller

This block is the coherence controller of one small direct-mapped write-back cache that sits on a shared atomic bus next to other caches of the same kind. Each line holds one data word, a tag and one of three states: invalid, shared (clean, read-only) or exclusive (the only copy, writable, dirty). Processor reads and writes that hit complete locally with no bus traffic. Misses are turned into bus transactions after arbitration. A miss that would displace a dirty line first writes that line back in its own transaction.

Alongside its own requests the controller watches the misses that other caches place on the bus. A snooped write miss to a line it holds clean drops that line. A snooped miss to a line it owns dirty makes it abort the memory access, supply the dirty word, and either keep a clean copy (read miss) or give the line up (write miss). A snoop that changes the line the controller is still waiting to win the bus for forces that request to restart from the lookup, so the transaction finally issued reflects the new line state.

Addresses split into an index (low `IDX_W` bits) and a tag (the remaining upper bits). Bus and snoop command codes are 0 = none, 1 = read miss, 2 = write miss, 3 = write back (the last on the bus only).

Top module: `msi_snoop_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, and `cpu_done`, `bus_req`, `bus_cmd`, `snp_abort` and `snp_dvld` are low; the first access to any address is a miss.
- R2: A processor read that finds a matching tag in shared or exclusive state raises `cpu_done` for exactly one cycle, in the cycle after the lookup cycle, with the line's word on `cpu_rdata`, and `bus_req` stays low.
- R3: A processor write that finds a matching tag in exclusive state completes in the same timing as R2 without bus traffic and replaces the line's word.
- R4: A read miss raises `bus_req` in the cycle after the lookup; one cycle after a cycle with `bus_gnt` high, `bus_req` is low and `bus_cmd` = 1 with the requested address for exactly one cycle; the line is then filled from `bus_fill_data` on the cycle `bus_fill_vld` is high, becomes shared, and `cpu_done` follows one cycle later with the fill word.
- R5: A write to an invalid line or to a matching shared line issues `bus_cmd` = 2 with the requested address; after the fill strobe the line is exclusive and holds the write data.
- R6: A miss whose index holds an exclusive line with another tag first issues `bus_cmd` = 3 carrying the victim's address and dirty word, and only after a second arbitration issues the read or write miss.
- R7: A miss whose index holds a shared line with another tag issues the miss directly with no write back.
- R8: A snooped write miss (`snp_cmd` = 2) to a matching shared line invalidates it without asserting `snp_abort`.
- R9: A snooped read miss (`snp_cmd` = 1) to a matching exclusive line asserts `snp_abort` in the same cycle, raises `snp_dvld` for one cycle in the next cycle with the dirty word on `snp_data`, and leaves the line shared.
- R10: A snooped write miss to a matching exclusive line aborts and supplies the word as in R9 and leaves the line invalid.
- R11: A snooped read miss to a shared line, or any snoop whose tag does not match, leaves the line unchanged and asserts neither `snp_abort` nor `snp_dvld`.
- R12: If, while `bus_req` is waiting for a grant, a snoop changes the line at the pending index, `bus_req` drops in the next cycle and the request is looked up again, so the transaction issued follows the updated line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd | output | 2 | Issued transaction: 0 none, 1 read miss, 2 write miss, 3 write back |
| bus_addr | output | ADDR_W | Address of the issued transaction |
| bus_wdata | output | DATA_W | Dirty word carried by a write back |
| bus_fill_vld | input | 1 | Fill word for the outstanding miss is present |
| bus_fill_data | input | DATA_W | Fill word |
| snp_cmd | input | 2 | Observed miss of another cache: 0 none, 1 read miss, 2 write miss |
| snp_addr | input | ADDR_W | Address of the observed miss |
| snp_abort | output | 1 | Memory must not answer; this cache owns the dirty word |
| snp_dvld | output | 1 | Strobe for the supplied dirty word |
| snp_data | output | DATA_W | Supplied dirty word |

## Verification
The hardest situation to reach from the ports is a snoop that lands on the very line a pending request is waiting for, in the short window between the bus request and the grant. The bench reaches it by holding the grant off, presenting the snoop in that window on a line it has first made dirty or shared through earlier accesses, and then checking that the request is withdrawn and that the transaction finally issued is the one the new line state calls for (a plain read miss instead of a write back, or a write miss after the shared copy is lost).

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHD = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  localparam logic [1:0] BC_NONE   = 2'd0;
  localparam logic [1:0] BC_RDMISS = 2'd1;
  localparam logic [1:0] BC_WRMISS = 2'd2;
  localparam logic [1:0] BC_WBACK  = 2'd3;

  typedef enum logic [2:0] {
    CS_IDLE = 3'd0,
    CS_WAIT = 3'd1,
    CS_XFER = 3'd2,
    CS_FILL = 3'd3,
    CS_DONE = 3'd4
  } ctl_st_e;
endpackage

// File: rtl/msi_tag_store.sv
module msi_tag_store
  import msi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output line_st_e         ra_st,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output line_st_e         rb_st,
  input  logic             w_en,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  line_st_e         w_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_e         st_q  [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
    end else if (w_en) begin
      st_q[w_idx] <= w_st;
    end
  end

  always_ff @(posedge clk) begin
    if (w_en) tag_q[w_idx] <= w_tag;
  end

  assign ra_tag = tag_q[ra_idx];
  assign ra_st  = st_q[ra_idx];
  assign rb_tag = tag_q[rb_idx];
  assign rb_st  = st_q[rb_idx];
endmodule

// File: rtl/msi_data_store.sv
module msi_data_store #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              w_en,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (w_en) mem_q[w_idx] <= w_data;
  end

  assign ra_data = mem_q[ra_idx];
  assign rb_data = mem_q[rb_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
(
  input  logic [1:0] cmd,
  input  logic       tag_eq,
  input  line_st_e   cur_st,
  output logic       abort,
  output logic       upd,
  output line_st_e   nxt_st
);
  logic owned_hit;

  assign owned_hit = tag_eq && (cur_st != LN_INV);

  always_comb begin
    abort  = 1'b0;
    upd    = 1'b0;
    nxt_st = cur_st;
    if (owned_hit) begin
      if (cur_st == LN_EXC && (cmd == BC_RDMISS || cmd == BC_WRMISS)) begin
        abort  = 1'b1;
        upd    = 1'b1;
        nxt_st = (cmd == BC_RDMISS) ? LN_SHD : LN_INV;
      end else if (cur_st == LN_SHD && cmd == BC_WRMISS) begin
        upd    = 1'b1;
        nxt_st = LN_INV;
      end
    end
  end
endmodule

// File: rtl/msi_snoop_cache_ctrl.sv
module msi_snoop_cache_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_fill_vld,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic              snp_dvld,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  // address split
  logic [IDX_W-1:0] req_idx, snp_idx;
  logic [TAG_W-1:0] req_tag, snp_tag;
  assign req_idx = cpu_addr[IDX_W-1:0];
  assign req_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  // storage read ports: a = processor side, b = snoop side
  logic [TAG_W-1:0]  a_tag, b_tag;
  line_st_e          a_st, b_st;
  logic [DATA_W-1:0] a_data, b_data;

  // single write ports shared by both sides
  logic              t_we, d_we;
  logic [IDX_W-1:0]  t_idx;
  logic [TAG_W-1:0]  t_tag;
  line_st_e          t_st;
  logic [DATA_W-1:0] d_data;

  msi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .ra_idx(req_idx), .ra_tag(a_tag), .ra_st(a_st),
    .rb_idx(snp_idx), .rb_tag(b_tag), .rb_st(b_st),
    .w_en(t_we), .w_idx(t_idx), .w_tag(t_tag), .w_st(t_st)
  );

  msi_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .w_en(d_we), .w_idx(req_idx), .w_data(d_data),
    .ra_idx(req_idx), .ra_data(a_data),
    .rb_idx(snp_idx), .rb_data(b_data)
  );

  // snoop decode
  logic     sn_abort, sn_upd;
  line_st_e sn_nst;

  msi_snoop_unit u_snoop (
    .cmd(snp_cmd), .tag_eq(b_tag == snp_tag), .cur_st(b_st),
    .abort(sn_abort), .upd(sn_upd), .nxt_st(sn_nst)
  );

  // processor lookup
  logic snp_busy, tag_hit, cpu_hit, need_wb, pend_hit;
  assign snp_busy = (snp_cmd != BC_NONE);
  assign tag_hit  = (a_st != LN_INV) && (a_tag == req_tag);
  assign cpu_hit  = tag_hit && (!cpu_we || a_st == LN_EXC);
  assign need_wb  = (a_st == LN_EXC) && (a_tag != req_tag);
  assign pend_hit = sn_upd && (snp_idx == req_idx);

  ctl_st_e           cst;
  logic              req_q, done_q, dvld_q;
  logic [1:0]        cmd_q;
  logic [ADDR_W-1:0] baddr_q;
  logic [DATA_W-1:0] bdata_q, rdata_q, sdata_q;

  // write-port steering: a snoop update always wins
  always_comb begin
    t_we   = 1'b0;
    t_idx  = req_idx;
    t_tag  = req_tag;
    t_st   = LN_INV;
    d_we   = 1'b0;
    d_data = cpu_wdata;
    if (sn_upd) begin
      t_we  = 1'b1;
      t_idx = snp_idx;
      t_tag = b_tag;
      t_st  = sn_nst;
    end else begin
      case (cst)
        CS_IDLE: d_we = cpu_req && !snp_busy && cpu_hit && cpu_we;
        CS_XFER: begin
          if (cmd_q == BC_WBACK) begin
            t_we  = 1'b1;
            t_tag = a_tag;
            t_st  = LN_INV;
          end
        end
        CS_FILL: begin
          if (bus_fill_vld) begin
            t_we   = 1'b1;
            t_st   = cpu_we ? LN_EXC : LN_SHD;
            d_we   = 1'b1;
            d_data = cpu_we ? cpu_wdata : bus_fill_data;
          end
        end
        default: ;
      endcase
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      cst     <= CS_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      dvld_q  <= 1'b0;
      cmd_q   <= BC_NONE;
      baddr_q <= '0;
      bdata_q <= '0;
      rdata_q <= '0;
      sdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      cmd_q  <= BC_NONE;
      dvld_q <= sn_abort;
      if (sn_abort) sdata_q <= b_data;
      case (cst)
        CS_IDLE: begin
          if (cpu_req && !snp_busy) begin
            if (cpu_hit) begin
              done_q  <= 1'b1;
              rdata_q <= cpu_we ? cpu_wdata : a_data;
              cst     <= CS_DONE;
            end else begin
              req_q <= 1'b1;
              cst   <= CS_WAIT;
            end
          end
        end
        CS_WAIT: begin
          if (pend_hit) begin
            req_q <= 1'b0;
            cst   <= CS_IDLE;
          end else if (bus_gnt) begin
            req_q <= 1'b0;
            cst   <= CS_XFER;
            if (need_wb) begin
              cmd_q   <= BC_WBACK;
              baddr_q <= {a_tag, req_idx};
              bdata_q <= a_data;
            end else begin
              cmd_q   <= cpu_we ? BC_WRMISS : BC_RDMISS;
              baddr_q <= cpu_addr;
            end
          end
        end
        CS_XFER: cst <= (cmd_q == BC_WBACK) ? CS_IDLE : CS_FILL;
        CS_FILL: begin
          if (bus_fill_vld) begin
            done_q  <= 1'b1;
            rdata_q <= cpu_we ? cpu_wdata : bus_fill_data;
            cst     <= CS_DONE;
          end
        end
        CS_DONE: cst <= CS_IDLE;
        default: cst <= CS_IDLE;
      endcase
    end
  end

  assign cpu_rdata = rdata_q;
  assign cpu_done  = done_q;
  assign bus_req   = req_q;
  assign bus_cmd   = cmd_q;
  assign bus_addr  = baddr_q;
  assign bus_wdata = bdata_q;
  assign snp_abort = sn_abort;
  assign snp_dvld  = dvld_q;
  assign snp_data  = sdata_q;
endmodule

// File: rtl/msi_snoop_cache_ctrl_chk.sv
module msi_snoop_cache_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [1:0] bus_cmd,
  input logic [1:0] snp_cmd,
  input logic       snp_abort,
  input logic       snp_dvld
);
  // R9: abort only answers an observed miss
  assert_abort_on_snoop_R9: assert property (@(posedge clk) disable iff (rst)
    snp_abort |-> (snp_cmd != 2'd0));

  // R9: the supplied word follows the abort by one cycle
  assert_strobe_after_abort_R9: assert property (@(posedge clk) disable iff (rst)
    snp_abort |=> snp_dvld);

  // R10: no strobe without a preceding abort
  assert_strobe_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
    snp_dvld |-> $past(snp_abort));

  // R4: a transaction appears only after a granted request
  assert_cmd_after_grant_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != 2'd0) |-> $past(bus_req && bus_gnt));

  // R6: the request is released once granted
  assert_req_released_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt) |=> !bus_req);

  // R6: each transaction lasts a single cycle
  assert_cmd_single_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != 2'd0) |=> (bus_cmd == 2'd0));

  // R2: completion is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);
endmodule

bind msi_snoop_cache_ctrl msi_snoop_cache_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cpu_done(cpu_done), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .snp_cmd(snp_cmd),
  .snp_abort(snp_abort), .snp_dvld(snp_dvld)
);

// File: tb/msi_snoop_cache_ctrl_tb.sv
module msi_snoop_cache_ctrl_tb;
  localparam int AW = 16, DW = 32, IW = 3, NL = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0, cpu_done, bus_req, bus_gnt = 0, bus_fill_vld = 0;
  logic snp_abort, snp_dvld;
  logic [AW-1:0] cpu_addr = '0, bus_addr, snp_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata, bus_wdata, bus_fill_data = '0, snp_data;
  logic [1:0] bus_cmd, snp_cmd = 2'd0;

  always #10 clk = ~clk;

  msi_snoop_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_fill_vld(bus_fill_vld), .bus_fill_data(bus_fill_data),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_abort(snp_abort),
    .snp_dvld(snp_dvld), .snp_data(snp_data)
  );

  // reference model: per-line tag, state (0 inv, 1 shd, 2 exc), word; backing memory
  int            m_tag [NL];
  int            m_st  [NL];
  logic [DW-1:0] m_dat [NL];
  logic [DW-1:0] mem [logic [AW-1:0]];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] memrd(input logic [AW-1:0] a);
    if (mem.exists(a)) return mem[a];
    return {a, ~a};
  endfunction

  task automatic grant(input int gd, input string rq);
    for (int i = 0; i < gd; i++) begin
      tick;
      chk(rq, "request held while waiting", bus_req, 1);
      chk(rq, "no transaction while waiting", bus_cmd, 0);
    end
    bus_gnt = 1;
    tick;
    bus_gnt = 0;
    chk(rq, "request released after grant", bus_req, 0);
  endtask

  // starts at the cycle where bus_req is already high for a miss
  task automatic finish_miss(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                             input int gd, input string rq);
    int idx = int'(a[IW-1:0]);
    logic [DW-1:0] fd;
    grant(gd, rq);
    chk(rq, "miss command", bus_cmd, we ? 2 : 1);
    chk(rq, "miss address", bus_addr, a);
    tick;
    chk(rq, "no completion before fill", cpu_done, 0);
    chk(rq, "transaction lasts one cycle", bus_cmd, 0);
    fd = memrd(a);
    bus_fill_vld = 1;
    bus_fill_data = fd;
    tick;
    bus_fill_vld = 0;
    chk(rq, "completion after fill", cpu_done, 1);
    if (!we) chk(rq, "fill word returned", cpu_rdata, fd);
    m_tag[idx] = int'(a >> IW);
    m_st[idx]  = we ? 2 : 1;
    m_dat[idx] = we ? wd : fd;
    cpu_req = 0;
    tick;
    chk(rq, "completion is a pulse", cpu_done, 0);
  endtask

  task automatic cpu_access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                            input int gd, input string rq);
    int idx = int'(a[IW-1:0]);
    int tg  = int'(a >> IW);
    bit hit;
    logic [AW-1:0] va;
    hit = m_st[idx] != 0 && m_tag[idx] == tg && (!we || m_st[idx] == 2);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    tick;
    if (hit) begin
      chk(rq, "hit completes next cycle", cpu_done, 1);
      chk(rq, "hit makes no bus request", bus_req, 0);
      if (!we) chk(rq, "hit data", cpu_rdata, m_dat[idx]);
      else m_dat[idx] = wd;
      cpu_req = 0;
      tick;
    end else begin
      chk(rq, "miss not complete at lookup", cpu_done, 0);
      if (m_st[idx] == 2 && m_tag[idx] != tg) begin
        va = AW'((m_tag[idx] << IW) | idx);
        chk(rq, "victim request", bus_req, 1);
        grant(gd, rq);
        chk(rq, "write back first", bus_cmd, 3);
        chk(rq, "write back address", bus_addr, va);
        chk(rq, "write back word", bus_wdata, m_dat[idx]);
        mem[va] = m_dat[idx];
        m_st[idx] = 0;
        tick;
        chk(rq, "write back ends", bus_cmd, 0);
        tick;
      end
      chk(rq, "miss request", bus_req, 1);
      finish_miss(we, a, wd, gd, rq);
    end
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input string rq);
    int idx = int'(a[IW-1:0]);
    int tg  = int'(a >> IW);
    bit hl, ab;
    hl = m_st[idx] != 0 && m_tag[idx] == tg;
    ab = hl && m_st[idx] == 2;
    snp_cmd = c; snp_addr = a;
    #1;
    chk(rq, "abort in snoop cycle", snp_abort, ab);
    tick;
    snp_cmd = 0;
    chk(rq, "data strobe", snp_dvld, ab);
    if (ab) chk(rq, "supplied word", snp_data, m_dat[idx]);
    if (hl) begin
      if (ab) mem[a] = m_dat[idx];
      if (c == 2) m_st[idx] = 0;
      else if (ab) m_st[idx] = 1;
    end
    tick;
    chk(rq, "strobe is a pulse", snp_dvld, 0);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    tick;
    // R1: idle outputs after reset
    chk("R1", "cpu_done", cpu_done, 0);
    chk("R1", "bus_req", bus_req, 0);
    chk("R1", "bus_cmd", bus_cmd, 0);
    chk("R1", "snp_abort", snp_abort, 0);
    chk("R1", "snp_dvld", snp_dvld, 0);
    cpu_access(0, 16'h0012, 0, 0, "R1");            // cold miss (R1, R4)
    cpu_access(0, 16'h0012, 0, 0, "R2");            // read hit in shared
    cpu_access(1, 16'h0012, 32'hA5A5_0001, 2, "R5"); // write to shared: write miss
    cpu_access(1, 16'h0012, 32'hA5A5_0002, 0, "R3"); // write hit in exclusive
    cpu_access(0, 16'h0012, 0, 0, "R2");            // read hit in exclusive
    cpu_access(0, 16'h0102, 0, 1, "R6");            // replace dirty line
    cpu_access(0, 16'h0012, 0, 0, "R6");            // written-back word refetched
    cpu_access(0, 16'h0202, 0, 0, "R7");            // replace shared line silently
    cpu_access(1, 16'h0027, 32'h1234_5678, 0, "R5"); // write to invalid line
    // R9: snooped read miss to dirty line
    cpu_access(1, 16'h0033, 32'hBEEF_0033, 0, "R4");
    snoop(2'd1, 16'h0033, "R9");
    cpu_access(0, 16'h0033, 0, 0, "R9");            // still readable
    cpu_access(1, 16'h0033, 32'hBEEF_1133, 0, "R9"); // shared now: write miss
    // R10: snooped write miss to dirty line
    snoop(2'd2, 16'h0033, "R10");
    cpu_access(0, 16'h0033, 0, 0, "R10");           // invalid now: miss
    // R8: snooped write miss to shared line
    snoop(2'd2, 16'h0033, "R8");
    cpu_access(0, 16'h0033, 0, 0, "R8");
    // R11: snoops that must not change the line
    snoop(2'd1, 16'h0033, "R11");
    snoop(2'd2, 16'h0133, "R11");
    snoop(2'd1, 16'h0034, "R11");
    cpu_access(0, 16'h0033, 0, 0, "R11");           // still a hit
    // R12 case 1: dirty victim taken by a snoop while waiting
    cpu_access(1, 16'h0045, 32'hCAFE_0001, 0, "R12");
    cpu_req = 1; cpu_we = 0; cpu_addr = 16'h0145;
    tick;
    chk("R12", "victim request raised", bus_req, 1);
    tick;
    chk("R12", "still waiting", bus_req, 1);
    snp_cmd = 2'd1; snp_addr = 16'h0045;
    #1;
    chk("R12", "abort during wait", snp_abort, 1);
    tick;
    snp_cmd = 0;
    chk("R12", "request withdrawn", bus_req, 0);
    chk("R12", "word supplied", snp_dvld, 1);
    chk("R12", "supplied word value", snp_data, 32'hCAFE_0001);
    mem[16'h0045] = 32'hCAFE_0001;
    m_st[5] = 1;
    tick;
    chk("R12", "request reissued", bus_req, 1);
    finish_miss(0, 16'h0145, 0, 1, "R12");           // must be a read miss, no write back
    // R12 case 2: shared copy lost while an upgrade waits
    cpu_access(0, 16'h0066, 0, 0, "R12");
    cpu_req = 1; cpu_we = 1; cpu_addr = 16'h0066; cpu_wdata = 32'h0DD0_0066;
    tick;
    chk("R12", "upgrade request raised", bus_req, 1);
    snp_cmd = 2'd2; snp_addr = 16'h0066;
    #1;
    chk("R12", "no abort for shared line", snp_abort, 0);
    tick;
    snp_cmd = 0;
    chk("R12", "upgrade withdrawn", bus_req, 0);
    m_st[6] = 0;
    tick;
    chk("R12", "upgrade reissued", bus_req, 1);
    finish_miss(1, 16'h0066, 32'h0DD0_0066, 0, "R12");
    cpu_access(0, 16'h0066, 0, 0, "R12");           // hit with the written word
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule